// File: doc/BRIEF.md
# Paged pseudo-PHY register bridge

This block is the target end of an indirect register window. A management interface, already decoded into single-cycle read and write strobes with a device address and a register address, reaches it at one fixed device address. Through a few 16-bit window registers, software can read and write a wider register space that is split into pages of 32-bit registers.

A page register selects the page and enables paged access. A command register holds the register offset and two request bits, one for write and one for read. Four data words carry the value that moves in either direction. A command runs for a fixed, configurable number of cycles. While it runs, its request bits stay set, so software polls the command register until they clear. A completed read fills the data words. A completed write stores data words 0 and 1 into the selected register.

Two kinds of page are served. The port status page is read-only and is built from live link, duplex and speed input vectors. A small bank of storage pages can be read and written.

Top module: `paged_window_bridge`

## Requirements
- R1: After reset every window register reads 0 and no command is pending (command register bits 1:0 read 0).
- R2: Only device address 0x1E is served. A write to any other device address changes no window register, and a read at any other device address returns 0 on `rdata`. A read at 0x1E with `rd_en` low also returns 0.
- R3: Window register 0x10 is the page register: bits 15:8 are the page number and bit 0 is the access enable. Its other bits read 0. Window offsets with no register behind them (for example 0x12) read 0.
- R4: Window register 0x11 is the command register: bits 15:8 are the register offset, bit 0 requests a write and bit 1 requests a read. Bits 7:2 read 0. A write that sets either request bit starts a command. The request bits read back set from the cycle after that write until, on the LATENCY-th rising clock edge after it (default 3), they clear. A write to 0x11 while a command is pending is ignored.
- R5: Window registers 0x18 to 0x1B are data words 0 to 3, least significant first, and can be read and written. A completed read puts bits 15:0 of the 32-bit result into word 0 and bits 31:16 into word 1, and clears words 2 and 3.
- R6: On page 0x01, offset 0x00 returns the link vector, bit p for port p, zero-extended to 32 bits.
- R7: On page 0x01, offset 0x08 returns the duplex vector, bit p for port p (1 = full duplex), zero-extended.
- R8: On page 0x01, offset 0x04 returns the speed summary: 2 bits per port, at bit position 2*p, with 0 = 10 Mb/s, 1 = 100 Mb/s and 2 = 1000 Mb/s.
- R9: A write command to page 0x01 changes nothing; a later read still returns the input vectors.
- R10: Pages 0x02 and 0x03 each hold 4 read/write 32-bit registers at offsets 0 to 3. A write stores {word1, word0} and a read returns it. Offsets of 4 and above on those pages read 0 and ignore writes. Unserved pages read 0.
- R11: When the page enable is 0 at issue, the command completes after the same latency but accesses nothing. A read then returns all-zero data words, and a write stores nothing.
- R12: A command with both request bits set performs only the write and leaves the data words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Management write strobe, one cycle per access |
| rd_en | input | 1 | Management read strobe |
| dev_addr | input | 5 | Management device address of the access |
| reg_addr | input | 5 | Window register address of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the same cycle as rd_en |
| link_in | input | 9 | Per-port link state |
| duplex_in | input | 9 | Per-port duplex state, 1 = full |
| speed_in | input | 18 | Per-port 2-bit speed code |

## Verification
A window read is combinational, so `rdata` is due in the cycle of `rd_en`. The bench raises the strobe on a falling edge and samples 1 ns later. A window write takes effect on the next rising edge. A command's request bits read set after that edge and are checked still set after the second edge. They are checked clear, with the data words loaded, only after the LATENCY-th edge (third by default), so the bench proves exact completion timing rather than only eventual completion. Ignored writes (foreign device, locked command register, status page, disabled page) are each followed by a read back of the state they could have touched.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   localparam int MGMT_AW = 5;
   localparam int WORD_W  = 16;
   localparam int WIDE_W  = 2 * WORD_W;

   localparam logic [MGMT_AW-1:0] WREG_PAGE  = 5'h10;
   localparam logic [MGMT_AW-1:0] WREG_CMD   = 5'h11;
   localparam logic [MGMT_AW-1:0] WREG_DATA0 = 5'h18;

   localparam logic [7:0] PG_STATUS  = 8'h01;
   localparam logic [7:0] OFF_LINK   = 8'h00;
   localparam logic [7:0] OFF_SPEED  = 8'h04;
   localparam logic [7:0] OFF_DUPLEX = 8'h08;

   localparam int OP_WR_BIT = 0;
   localparam int OP_RD_BIT = 1;
endpackage

// File: rtl/pwb_window.sv
module pwb_window
   import pwb_pkg::*;
#(
   parameter int NUM_DATA = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [MGMT_AW-1:0]  reg_addr,
   input  logic [WORD_W-1:0]   wdata,
   input  logic                cmd_done,
   input  logic                load_en,
   input  logic [WIDE_W-1:0]   load_val,
   output logic [7:0]          page_num,
   output logic                page_en,
   output logic [7:0]          cmd_off,
   output logic [1:0]          cmd_op,
   output logic [WIDE_W-1:0]   data_lo,
   output logic [WORD_W-1:0]   rdata
);
   logic [WORD_W-1:0] data_q [NUM_DATA];
   logic              cmd_busy;

   if (NUM_DATA < 2 || NUM_DATA > 8) begin : g_bad_data
      $error("pwb_window: NUM_DATA must be 2..8");
   end

   assign cmd_busy = |cmd_op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_num <= '0;
         page_en  <= 1'b0;
      end else if (host_wr && reg_addr == WREG_PAGE) begin
         page_num <= wdata[15:8];
         page_en  <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_off <= '0;
         cmd_op  <= '0;
      end else if (cmd_done) begin
         cmd_op  <= '0;
      end else if (host_wr && reg_addr == WREG_CMD && !cmd_busy) begin
         cmd_off <= wdata[15:8];
         cmd_op  <= wdata[1:0];
      end
   end

   for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
      localparam logic [MGMT_AW-1:0] MY_ADDR = WREG_DATA0 + MGMT_AW'(i);
      logic [WORD_W-1:0] fill;
      if (i == 0) begin : g_w0
         assign fill = load_val[WORD_W-1:0];
      end else if (i == 1) begin : g_w1
         assign fill = load_val[WIDE_W-1:WORD_W];
      end else begin : g_wn
         assign fill = '0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[i] <= '0;
         end else if (load_en) begin
            data_q[i] <= fill;
         end else if (host_wr && reg_addr == MY_ADDR) begin
            data_q[i] <= wdata;
         end
      end
   end

   assign data_lo = {data_q[1], data_q[0]};

   always_comb begin
      rdata = '0;
      if (host_rd) begin
         if (reg_addr == WREG_PAGE) begin
            rdata = {page_num, 7'd0, page_en};
         end else if (reg_addr == WREG_CMD) begin
            rdata = {cmd_off, 6'd0, cmd_op};
         end else begin
            for (int k = 0; k < NUM_DATA; k++) begin
               if (reg_addr == WREG_DATA0 + MGMT_AW'(k)) rdata = data_q[k];
            end
         end
      end
   end
endmodule

// File: rtl/pwb_cmd_seq.sv
module pwb_cmd_seq #(
   parameter int LATENCY = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue,
   input  logic [7:0] issue_page,
   input  logic       issue_en,
   output logic       done,
   output logic [7:0] act_page,
   output logic       act_en
);
   localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

   logic             active;
   logic [CNT_W-1:0] cnt;

   if (LATENCY < 1) begin : g_bad_lat
      $error("pwb_cmd_seq: LATENCY must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         act_page <= '0;
         act_en   <= 1'b0;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end else if (issue) begin
         active   <= 1'b1;
         cnt      <= CNT_LOAD;
         act_page <= issue_page;
         act_en   <= issue_en;
      end
   end

   assign done = active && (cnt == '0);
endmodule

// File: rtl/pwb_status_page.sv
module pwb_status_page
   import pwb_pkg::*;
#(
   parameter int NUM_PORTS = 9
) (
   input  logic [NUM_PORTS-1:0]   link_in,
   input  logic [NUM_PORTS-1:0]   duplex_in,
   input  logic [2*NUM_PORTS-1:0] speed_in,
   input  logic [7:0]             offset,
   output logic [WIDE_W-1:0]      value
);
   logic [WORD_W-1:0] link_w;
   logic [WORD_W-1:0] dup_w;
   logic [WIDE_W-1:0] spd_w;

   if (NUM_PORTS < 1 || NUM_PORTS > WORD_W) begin : g_bad_ports
      $error("pwb_status_page: NUM_PORTS must be 1..16");
   end

   for (genvar p = 0; p < WORD_W; p++) begin : g_port
      if (p < NUM_PORTS) begin : g_on
         assign link_w[p]         = link_in[p];
         assign dup_w[p]          = duplex_in[p];
         assign spd_w[2*p +: 2]   = speed_in[2*p +: 2];
      end else begin : g_off
         assign link_w[p]         = 1'b0;
         assign dup_w[p]          = 1'b0;
         assign spd_w[2*p +: 2]   = 2'b00;
      end
   end

   always_comb begin
      case (offset)
         OFF_LINK:   value = {{WORD_W{1'b0}}, link_w};
         OFF_DUPLEX: value = {{WORD_W{1'b0}}, dup_w};
         OFF_SPEED:  value = spd_w;
         default:    value = '0;
      endcase
   end
endmodule

// File: rtl/pwb_store.sv
module pwb_store
   import pwb_pkg::*;
#(
   parameter logic [7:0] BASE  = 8'h02,
   parameter int         PAGES = 2,
   parameter int         DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [7:0]        page,
   input  logic [7:0]        offset,
   input  logic [WIDE_W-1:0] wval,
   output logic [WIDE_W-1:0] rval
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [WIDE_W-1:0] page_rd [PAGES];
   logic              in_range;
   logic [IDX_W-1:0]  idx;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH || DEPTH > 256) begin : g_bad_depth
      $error("pwb_store: DEPTH must be a power of two in 2..256");
   end
   if (PAGES < 1 || int'(BASE) + PAGES > 256 || BASE <= PG_STATUS) begin : g_bad_pages
      $error("pwb_store: storage pages must lie above the status page");
   end

   assign in_range = (int'(offset) < DEPTH);
   assign idx      = offset[IDX_W-1:0];

   for (genvar g = 0; g < PAGES; g++) begin : g_page
      localparam logic [7:0] MY_PAGE = BASE + 8'(g);
      logic [WIDE_W-1:0] row [DEPTH];
      logic              sel;

      assign sel = (page == MY_PAGE) && in_range;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) row[e] <= '0;
         end else if (we && sel) begin
            row[idx] <= wval;
         end
      end

      assign page_rd[g] = sel ? row[idx] : '0;
   end

   always_comb begin
      rval = '0;
      for (int g = 0; g < PAGES; g++) rval = rval | page_rd[g];
   end
endmodule

// File: rtl/paged_window_bridge.sv
module paged_window_bridge
   import pwb_pkg::*;
#(
   parameter logic [MGMT_AW-1:0] DEV_ADDR    = 5'h1E,
   parameter int                 LATENCY     = 3,
   parameter int                 NUM_PORTS   = 9,
   parameter logic [7:0]         STORE_BASE  = 8'h02,
   parameter int                 STORE_PAGES = 2,
   parameter int                 STORE_DEPTH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [MGMT_AW-1:0]     dev_addr,
   input  logic [MGMT_AW-1:0]     reg_addr,
   input  logic [WORD_W-1:0]      wdata,
   output logic [WORD_W-1:0]      rdata,
   input  logic [NUM_PORTS-1:0]   link_in,
   input  logic [NUM_PORTS-1:0]   duplex_in,
   input  logic [2*NUM_PORTS-1:0] speed_in
);
   logic              dev_hit, host_wr, host_rd;
   logic [7:0]        page_num, cmd_off, act_page;
   logic              page_en, act_en;
   logic [1:0]        cmd_op;
   logic [WIDE_W-1:0] data_lo, status_val, store_val, lookup, load_val;
   logic              issue, done, load_en, store_we, rd_only;

   assign dev_hit = (dev_addr == DEV_ADDR);
   assign host_wr = wr_en && dev_hit;
   assign host_rd = rd_en && dev_hit;

   assign issue = host_wr && (reg_addr == WREG_CMD) && (cmd_op == 2'b00)
                  && (wdata[1:0] != 2'b00);

   pwb_window #(.NUM_DATA(4)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_wr  (host_wr),
      .host_rd  (host_rd),
      .reg_addr (reg_addr),
      .wdata    (wdata),
      .cmd_done (done),
      .load_en  (load_en),
      .load_val (load_val),
      .page_num (page_num),
      .page_en  (page_en),
      .cmd_off  (cmd_off),
      .cmd_op   (cmd_op),
      .data_lo  (data_lo),
      .rdata    (rdata)
   );

   pwb_cmd_seq #(.LATENCY(LATENCY)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_page (page_num),
      .issue_en   (page_en),
      .done       (done),
      .act_page   (act_page),
      .act_en     (act_en)
   );

   pwb_status_page #(.NUM_PORTS(NUM_PORTS)) u_stat (
      .link_in   (link_in),
      .duplex_in (duplex_in),
      .speed_in  (speed_in),
      .offset    (cmd_off),
      .value     (status_val)
   );

   pwb_store #(
      .BASE  (STORE_BASE),
      .PAGES (STORE_PAGES),
      .DEPTH (STORE_DEPTH)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (store_we),
      .page   (act_page),
      .offset (cmd_off),
      .wval   (data_lo),
      .rval   (store_val)
   );

   assign rd_only  = cmd_op[OP_RD_BIT] && !cmd_op[OP_WR_BIT];
   assign store_we = done && cmd_op[OP_WR_BIT] && act_en;
   assign load_en  = done && rd_only;
   assign lookup   = (act_page == PG_STATUS) ? status_val : store_val;
   assign load_val = act_en ? lookup : '0;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
   import pwb_pkg::*;
#(
   parameter logic [MGMT_AW-1:0] DEV_ADDR = 5'h1E,
   parameter int                 LATENCY  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [MGMT_AW-1:0] dev_addr,
   input logic [MGMT_AW-1:0] reg_addr,
   input logic [WORD_W-1:0] wdata,
   input logic [WORD_W-1:0] rdata,
   input logic [7:0]        page_num,
   input logic              page_en,
   input logic [7:0]        cmd_off,
   input logic [1:0]        cmd_op,
   input logic [WIDE_W-1:0] data_lo
);
   logic        busy;
   int unsigned busy_cycles;
   logic        dis_read;
   logic        cmd_wr;

   assign busy   = |cmd_op;
   assign cmd_wr = wr_en && dev_addr == DEV_ADDR && reg_addr == WREG_CMD;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_cycles <= 0;
         dis_read    <= 1'b0;
      end else begin
         busy_cycles <= busy ? busy_cycles + 1 : 0;
         if (cmd_wr && !busy && wdata[1:0] != 2'b00)
            dis_read <= (wdata[1:0] == 2'b10) && !page_en;
      end
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cycles == LATENCY); // R4

   AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> (cmd_off == $past(cmd_off)) &&
                           (cmd_op == $past(cmd_op) || cmd_op == 2'b00)); // R4

   AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dev_addr != DEV_ADDR && !busy) |=>
         $stable(page_num) && $stable(page_en) && $stable(data_lo)); // R2

   AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || dev_addr != DEV_ADDR) |-> rdata == '0); // R2

   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && dis_read) |-> data_lo == '0); // R11
endmodule

bind paged_window_bridge pwb_checker #(
   .DEV_ADDR (DEV_ADDR),
   .LATENCY  (LATENCY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .dev_addr (dev_addr),
   .reg_addr (reg_addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .page_num (page_num),
   .page_en  (page_en),
   .cmd_off  (cmd_off),
   .cmd_op   (cmd_op),
   .data_lo  (data_lo)
);

// File: tb/paged_window_bridge_tb.sv
module paged_window_bridge_tb;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  dev_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [8:0]  link_in = '0;
   logic [8:0]  duplex_in = '0;
   logic [17:0] speed_in = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   paged_window_bridge u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .dev_addr  (dev_addr),
      .reg_addr  (reg_addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .link_in   (link_in),
      .duplex_in (duplex_in),
      .speed_in  (speed_in)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic mwrite(input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1; dev_addr = dev; reg_addr = ra; wdata = v;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic mread(input logic [4:0] dev, input logic [4:0] ra, output logic [15:0] v);
      @(negedge clk);
      rd_en = 1'b1; dev_addr = dev; reg_addr = ra;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [4:0] ra, input logic [15:0] v);
      mwrite(5'h1E, ra, v);
   endtask

   task automatic rd_chk(input logic [4:0] ra, input logic [15:0] exp, input string tag);
      logic [15:0] v;
      mread(5'h1E, ra, v);
      chk(tag, v, exp);
   endtask

   // Issue a command and check its busy window cycle by cycle (R4).
   task automatic run_cmd(input logic [7:0] off, input logic [1:0] op);
      wr(5'h11, {off, 6'd0, op});
      rd_chk(5'h11, {off, 6'd0, op}, "R4 busy after issue");
      repeat (LAT - 1) @(posedge clk);
      rd_chk(5'h11, {off, 6'd0, op}, "R4 busy before last edge");
      @(posedge clk);
      rd_chk(5'h11, {off, 8'h00}, "R4 clear at completion");
   endtask

   task automatic t_reset;
      rd_chk(5'h10, 16'h0, "R1 page reg");
      rd_chk(5'h11, 16'h0, "R1 cmd reg");
      for (int i = 0; i < 4; i++) rd_chk(5'h18 + 5'(i), 16'h0, "R1 data word");
   endtask

   task automatic t_page;
      wr(5'h10, 16'hABFF);
      rd_chk(5'h10, 16'hAB01, "R3 page readback");
      rd_chk(5'h12, 16'h0, "R3 unmapped offset");
   endtask

   task automatic t_foreign;
      logic [15:0] v;
      mwrite(5'h01, 5'h10, 16'h5501);
      mwrite(5'h1F, 5'h18, 16'hDEAD);
      rd_chk(5'h10, 16'hAB01, "R2 page untouched");
      rd_chk(5'h18, 16'h0, "R2 data untouched");
      mread(5'h01, 5'h10, v);
      chk("R2 foreign read zero", v, 16'h0);
      mwrite(5'h1D, 5'h11, 16'h0002);
      rd_chk(5'h11, 16'h0, "R2 no command started");
   endtask

   task automatic t_data;
      for (int i = 0; i < 4; i++) wr(5'h18 + 5'(i), 16'h1111 * 16'(i + 1));
      for (int i = 0; i < 4; i++) rd_chk(5'h18 + 5'(i), 16'h1111 * 16'(i + 1), "R5 data rw");
   endtask

   task automatic t_status;
      logic [31:0] exp_spd;
      logic [1:0]  code;
      link_in   = 9'h155;
      duplex_in = 9'h10A;
      exp_spd   = '0;
      for (int p = 0; p < 9; p++) begin
         code = 2'(p % 3);
         speed_in[2*p +: 2] = code;
         exp_spd = exp_spd | (32'(code) << (2 * p));
      end
      wr(5'h10, 16'h0101);
      wr(5'h1A, 16'hFFFF);
      wr(5'h1B, 16'hFFFF);
      run_cmd(8'h00, 2'b10);
      rd_chk(5'h18, 16'h0155, "R6 link word0");
      rd_chk(5'h19, 16'h0000, "R6 link word1");
      rd_chk(5'h1A, 16'h0000, "R5 word2 cleared");
      rd_chk(5'h1B, 16'h0000, "R5 word3 cleared");
      run_cmd(8'h08, 2'b10);
      rd_chk(5'h18, 16'h010A, "R7 duplex");
      run_cmd(8'h04, 2'b10);
      rd_chk(5'h18, exp_spd[15:0], "R8 speed low");
      rd_chk(5'h19, exp_spd[31:16], "R8 speed high");
   endtask

   task automatic t_status_ro;
      wr(5'h18, 16'h0000);
      wr(5'h19, 16'h0000);
      run_cmd(8'h00, 2'b01);
      run_cmd(8'h00, 2'b10);
      rd_chk(5'h18, 16'h0155, "R9 status not written");
   endtask

   task automatic t_store;
      wr(5'h10, 16'h0201);
      wr(5'h18, 16'h1234); wr(5'h19, 16'h5678);
      run_cmd(8'h02, 2'b01);
      wr(5'h10, 16'h0301);
      wr(5'h18, 16'h9ABC); wr(5'h19, 16'hDEF0);
      run_cmd(8'h02, 2'b01);
      run_cmd(8'h05, 2'b01);
      wr(5'h10, 16'h0201);
      run_cmd(8'h02, 2'b10);
      rd_chk(5'h18, 16'h1234, "R10 page2 low");
      rd_chk(5'h19, 16'h5678, "R10 page2 high");
      wr(5'h10, 16'h0301);
      run_cmd(8'h02, 2'b10);
      rd_chk(5'h18, 16'h9ABC, "R10 page3 low");
      rd_chk(5'h19, 16'hDEF0, "R10 page3 high");
      run_cmd(8'h05, 2'b10);
      rd_chk(5'h18, 16'h0000, "R10 out of range offset");
      wr(5'h10, 16'h0701);
      run_cmd(8'h00, 2'b10);
      rd_chk(5'h19, 16'h0000, "R10 unserved page");
   endtask

   task automatic t_disabled;
      wr(5'h10, 16'h0200);
      wr(5'h18, 16'hAAAA); wr(5'h19, 16'hBBBB);
      run_cmd(8'h02, 2'b10);
      rd_chk(5'h18, 16'h0000, "R11 disabled read word0");
      rd_chk(5'h19, 16'h0000, "R11 disabled read word1");
      wr(5'h18, 16'h7777); wr(5'h19, 16'h8888);
      run_cmd(8'h01, 2'b01);
      wr(5'h10, 16'h0201);
      run_cmd(8'h01, 2'b10);
      rd_chk(5'h18, 16'h0000, "R11 disabled write stored nothing");
   endtask

   task automatic t_both;
      wr(5'h18, 16'hCAFE); wr(5'h19, 16'hF00D);
      run_cmd(8'h03, 2'b11);
      rd_chk(5'h18, 16'hCAFE, "R12 data kept low");
      rd_chk(5'h19, 16'hF00D, "R12 data kept high");
      wr(5'h18, 16'h0); wr(5'h19, 16'h0);
      run_cmd(8'h03, 2'b10);
      rd_chk(5'h18, 16'hCAFE, "R12 write happened");
   endtask

   task automatic t_lock;
      wr(5'h11, 16'h0102);
      wr(5'h11, 16'h0301);
      repeat (LAT - 1) @(posedge clk);
      rd_chk(5'h11, 16'h0100, "R4 write while busy ignored");
      rd_chk(5'h18, 16'h5678 & 16'h0 | 16'h0000, "R4 lock read page2 off1");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_page();
      t_foreign();
      t_data();
      t_status();
      t_status_ro();
      t_store();
      t_disabled();
      t_both();
      t_lock();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule